// File: doc/BRIEF.md
# Freezable Double-Buffered Control Register Bank

This block holds the control settings of a multi-channel audio codec behind a simple synchronous byte-wide write/read port. A subset of the registers (per-channel volume, channel polarity inversion and the mixing-pair selects) is double-buffered. Host writes to these registers always land in a staging copy. Their active copy, which drives the parallel outputs, follows the staging copy only while the freeze bit is clear.

To apply several changes at once, the host sets freeze, writes all of the new values, and then clears freeze. On the clock edge that captures the write clearing freeze, every staged value moves to the active outputs together. The remaining control bits are not buffered and take effect on the cycle after their write. These bits are freeze, the interpolation roll-off select, the high-pass offset hold, and the two serial-port master selects.

Reads are combinational. A read of a buffered address returns the staged value, so pending writes can be checked while the bank is frozen.

Top module: `freeze_ctrl_bank`

## Requirements
- R1: After reset, all active outputs and all control bits are 0, the bank is not frozen, and every register reads back 0x00.
- R2: While freeze is 0, a write to a buffered register appears on its active output in the cycle after the write.
- R3: While freeze is 1, the buffered active outputs hold their values. Writes to buffered registers are still accepted, and reading those addresses returns the staged value.
- R4: The write that clears freeze makes all staged values active on the same clock edge, visible in the next cycle.
- R5: The control register sits at address 0x0E and has no buffering. Bit 0 is freeze. Bit 1 selects slow roll-off (0 = fast). Bit 2 holds the DC offset estimate. Bit 3 makes the codec serial port master. Bit 4 makes the auxiliary serial port master. Each bit takes effect on the cycle after the write, whether or not the bank is frozen, and bits 7:5 read as 0.
- R6: Writes to unmapped addresses change no output and no register, and unmapped addresses read back 0x00.
- R7: The buffered map is as follows. Volume channel k is at 0x0F+k (k = 0..7) and drives `vol_o[8k+7:8k]`. The invert register is at 0x17. Mixing pair k is at 0x18+k (k = 0..3) and drives `mix_o[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| vol_o | output | 64 | Active volume values, 8 bits per channel |
| inv_o | output | 8 | Active channel invert mask |
| mix_o | output | 32 | Active mixing-pair values, 8 bits per pair |
| freeze_o | output | 1 | Current freeze bit |
| filt_slow_o | output | 1 | Interpolation roll-off select, 1 = slow |
| hpf_hold_o | output | 1 | Hold DC offset estimate |
| codec_master_o | output | 1 | Codec serial port master select |
| aux_master_o | output | 1 | Auxiliary serial port master select |

## Verification
Every output change is due exactly one cycle after the write that causes it. An unfrozen buffered write, a control-bit write and the freeze-clearing commit all follow this timing. A frozen write is never due on the outputs. Read data is due in the same cycle as the address. The bench drives inputs on the falling edge. Its reference model is updated just after the rising edge that captures a write, and it compares all outputs on every following falling edge. Read-back is checked 1 ns after the address settles, so each result is sampled in the cycle where it is due.

// File: rtl/freeze_ctrl_bank.sv
module freeze_ctrl_bank #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int NVOL = 8,
  parameter int NMIX = 4,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h0E,
  parameter logic [AW-1:0] FRZ_BASE = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [NVOL*DW-1:0] vol_o,
  output logic [DW-1:0]    inv_o,
  output logic [NMIX*DW-1:0] mix_o,
  output logic             freeze_o,
  output logic             filt_slow_o,
  output logic             hpf_hold_o,
  output logic             codec_master_o,
  output logic             aux_master_o
);
  localparam int NFRZ = NVOL + 1 + NMIX;
  localparam int INV_IDX = NVOL;
  localparam int MIX_IDX = NVOL + 1;
  localparam int NCTL = 5;

  logic [NCTL-1:0] ctrl, ctrl_nxt;
  logic [DW-1:0]   stg [NFRZ];
  logic [DW-1:0]   act [NFRZ];

  assign ctrl_nxt = (wr_en && addr == CTRL_ADDR) ? wdata[NCTL-1:0] : ctrl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_nxt;

  for (genvar i = 0; i < NFRZ; i++) begin : g_reg
    localparam logic [AW-1:0] A_I = FRZ_BASE + AW'(i);
    logic [DW-1:0] nxt;
    assign nxt = (wr_en && addr == A_I) ? wdata : stg[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        stg[i] <= '0;
        act[i] <= '0;
      end else begin
        stg[i] <= nxt;
        if (!ctrl_nxt[0]) act[i] <= nxt;
      end
  end

  for (genvar k = 0; k < NVOL; k++) begin : g_vol
    assign vol_o[k*DW +: DW] = act[k];
  end
  for (genvar k = 0; k < NMIX; k++) begin : g_mix
    assign mix_o[k*DW +: DW] = act[MIX_IDX + k];
  end
  assign inv_o = act[INV_IDX];

  assign freeze_o       = ctrl[0];
  assign filt_slow_o    = ctrl[1];
  assign hpf_hold_o     = ctrl[2];
  assign codec_master_o = ctrl[3];
  assign aux_master_o   = ctrl[4];

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = DW'(ctrl);
    for (int i = 0; i < NFRZ; i++)
      if (addr == FRZ_BASE + AW'(i)) rdata = stg[i];
  end
endmodule

module freeze_ctrl_bank_chk #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int NVOL = 8,
  parameter int NMIX = 4,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h0E,
  parameter logic [AW-1:0] FRZ_BASE = 8'h0F
) (
  input logic clk, rst_n, wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [NVOL*DW-1:0] vol_o,
  input logic [DW-1:0] inv_o,
  input logic [NMIX*DW-1:0] mix_o,
  input logic freeze_o, filt_slow_o, hpf_hold_o, codec_master_o, aux_master_o
);
  localparam int NFRZ = NVOL + 1 + NMIX;
  localparam logic [AW-1:0] INV_ADDR = FRZ_BASE + AW'(NVOL);
  logic unmapped;
  assign unmapped = addr != CTRL_ADDR &&
                    (int'(addr) < int'(FRZ_BASE) || int'(addr) >= int'(FRZ_BASE) + NFRZ);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (vol_o == '0 && inv_o == '0 && mix_o == '0 && !freeze_o && !filt_slow_o));

  // R2
  unfrozen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == INV_ADDR && !freeze_o) |=> inv_o == $past(wdata));

  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> $stable({vol_o, inv_o, mix_o}));

  // R5
  ctrl_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR) |=>
      (filt_slow_o == $past(wdata[1]) && hpf_hold_o == $past(wdata[2]) &&
       codec_master_o == $past(wdata[3]) && aux_master_o == $past(wdata[4])));

  // R6
  unmapped_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=>
      $stable({vol_o, inv_o, mix_o, freeze_o, filt_slow_o, hpf_hold_o, codec_master_o, aux_master_o}));
endmodule

bind freeze_ctrl_bank freeze_ctrl_bank_chk #(
  .DW(DW), .AW(AW), .NVOL(NVOL), .NMIX(NMIX), .CTRL_ADDR(CTRL_ADDR), .FRZ_BASE(FRZ_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .vol_o(vol_o), .inv_o(inv_o), .mix_o(mix_o), .freeze_o(freeze_o),
  .filt_slow_o(filt_slow_o), .hpf_hold_o(hpf_hold_o),
  .codec_master_o(codec_master_o), .aux_master_o(aux_master_o)
);

// File: tb/freeze_ctrl_bank_tb.sv
`timescale 1ns/1ps
module freeze_ctrl_bank_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [63:0] vol_o;
  logic [7:0] inv_o;
  logic [31:0] mix_o;
  logic freeze_o, filt_slow_o, hpf_hold_o, codec_master_o, aux_master_o;
  int errors = 0, checks = 0;
  bit done = 0;

  int m_stg[13], m_act[13], m_ctl;

  always #4 clk = ~clk;

  freeze_ctrl_bank dut_i (.*);

  function automatic int m_read(int a);
    if (a == 'h0E) return m_ctl;
    if (a >= 'h0F && a <= 'h1B) return m_stg[a - 'h0F];
    return 0;
  endfunction

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // per-clock comparison against the model (R1 R2 R3 R4 R5 R7)
  always @(negedge clk) if (rst_n && !done) begin
    for (int k = 0; k < 8; k++) chk("R2/R3/R4 vol", int'(vol_o[8*k +: 8]), m_act[k]);
    chk("R2/R3/R4 inv", int'(inv_o), m_act[8]);
    for (int k = 0; k < 4; k++) chk("R2/R3/R4 mix", int'(mix_o[8*k +: 8]), m_act[9 + k]);
    chk("R5 ctrl", int'({aux_master_o, codec_master_o, hpf_hold_o, filt_slow_o, freeze_o}), m_ctl);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 8'(a); wdata = 8'(d); wr_en = 1;
    @(posedge clk);
    if (a == 'h0E) m_ctl = d & 'h1F;
    if (a >= 'h0F && a <= 'h1B) m_stg[a - 'h0F] = d & 'hFF;
    if ((m_ctl & 1) == 0) for (int i = 0; i < 13; i++) m_act[i] = m_stg[i];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string req, int a);
    addr = 8'(a);
    #1;
    chk(req, int'(rdata), m_read(a));
  endtask

  initial begin
    for (int i = 0; i < 13; i++) begin m_stg[i] = 0; m_act[i] = 0; end
    m_ctl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 vol", int'(vol_o[7:0]), 0);
    chk("R1 freeze", int'(freeze_o), 0);
    rd("R1 read 0x0F", 'h0F);
    rd("R1 read ctrl", 'h0E);
    rst_n = 1;
    // R2 / R7 unfrozen writes
    for (int k = 0; k < 8; k++) wr('h0F + k, 'h10 + k * 3);
    wr('h17, 'hA5);
    for (int k = 0; k < 4; k++) wr('h18 + k, 'h60 + k);
    chk("R7 vol ch3 lane", int'(vol_o[31:24]), 'h19);
    chk("R7 mix pair2 lane", int'(mix_o[23:16]), 'h62);
    chk("R2 inv", int'(inv_o), 'hA5);
    // R3 freeze and stage
    wr('h0E, 'h01);
    wr('h11, 'hAA);
    wr('h1B, 'h55);
    wr('h17, 'h3C);
    chk("R3 vol ch2 held", int'(vol_o[23:16]), 'h16);
    chk("R3 inv held", int'(inv_o), 'hA5);
    rd("R3 staged read 0x11", 'h11);
    rd("R3 staged read 0x1B", 'h1B);
    // R5 control bits while frozen
    wr('h0E, 'hE3);
    chk("R5 slow rolloff", int'(filt_slow_o), 1);
    chk("R5 still frozen", int'(freeze_o), 1);
    rd("R5 upper bits zero", 'h0E);
    wr('h1A, 'h77);
    // R4 commit
    wr('h0E, 'h1E);
    chk("R4 vol ch2", int'(vol_o[23:16]), 'hAA);
    chk("R4 mix3", int'(mix_o[31:24]), 'h55);
    chk("R4 mix2", int'(mix_o[23:16]), 'h77);
    chk("R4 inv", int'(inv_o), 'h3C);
    chk("R5 masters", int'({aux_master_o, codec_master_o, hpf_hold_o}), 7);
    // R6 unmapped
    wr('h05, 'hFF);
    wr('h30, 'h01);
    wr('h0D, 'h01);
    rd("R6 read 0x05", 'h05);
    rd("R6 read 0x30", 'h30);
    chk("R6 not frozen", int'(freeze_o), 0);
    // R2 again after commit, unfrozen
    wr('h0F, 'hC1);
    chk("R2 vol ch0", int'(vol_o[7:0]), 'hC1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule